// File: doc/BRIEF.md
# Selectable Reference Clock Divider

This block sits in the reference path of a frequency synthesizer. It takes a free-running oscillator clock and divides it to the phase-comparison rate. The oscillator itself lives outside the block, which sees only a digital clock in the 0.1 MHz to 10.24 MHz range. The total division is 2^SHORT_LOG2 when the ratio select is high and twice that when it is low. The first stage of the chain is a divide-by-2, and its output is also brought out as a half-rate tap. With the default SHORT_LOG2 = 10 and a 10.24 MHz clock, the tap runs at 5.12 MHz. The reference is then 10 kHz with the select high, or 5 kHz with it low.

The block presents the reference in two forms. The first is a strobe, one oscillator cycle wide, that a phase comparator can sample. The second is a 50% square wave. An undriven select pin is expected to be tied high at chip level, so the 10 kHz ratio is the default. A change of the select is only taken up at a period boundary, so a reference period is never cut short or stretched partway through.

Top module: `ref_clk_div`

## Requirements
- R1: While rst_ni is low, half_o, ref_stb_o and ref_sq_o are all 0, and asserting reset at any time clears every divider stage.
- R2: half_o is 1 after each odd-numbered rising clock edge following reset release and 0 after each even-numbered one, so it is the clock divided by 2 with 50% duty.
- R3: ref_stb_o is high for exactly one clock cycle per reference period, and the first strobe is high right after rising edge N following reset release, where N is the active ratio.
- R4: A period that starts with ratio_sel_i = 1 lasts 2^SHORT_LOG2 clock cycles (1024 by default), counting the divide-by-2 stage.
- R5: A period that starts with ratio_sel_i = 0 lasts 2^(SHORT_LOG2+1) clock cycles (2048 by default).
- R6: ratio_sel_i is sampled only on the edge that ends a period, so a change or a brief pulse of the select in mid-period leaves that period's length unchanged.
- R7: ref_sq_o rises on the same edge as ref_stb_o and stays high for exactly half of each period.
- R8: The first period after reset release uses the ratio given by ratio_sel_i at the first rising edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_sel_i | input | 1 | 1 selects total divide 2^SHORT_LOG2, 0 selects twice that |
| half_o | output | 1 | Clock divided by 2 |
| ref_stb_o | output | 1 | One-cycle strobe per reference period |
| ref_sq_o | output | 1 | Reference as a 50% square wave |

## Verification
The bench builds the block with SHORT_LOG2 = 4, which gives periods of 16 and 32 cycles. At that size, dozens of whole periods, both directions of ratio change, a select pulse inside one period and a reset taken mid-run all fit in a few hundred cycles. The logic is the same at the default of 10, because the terminal and midpoint counts are derived from the parameter. The smallest legal value, 3, keeps a nonzero midpoint for the short ratio.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

  typedef enum logic {
    RATIO_SHORT = 1'b0,
    RATIO_LONG  = 1'b1
  } ratio_e;

  // select high keeps the short (higher-frequency) ratio
  function automatic ratio_e sel_to_ratio(input logic sel);
    return sel ? RATIO_SHORT : RATIO_LONG;
  endfunction

endpackage

// File: rtl/rdiv_half.sv
module rdiv_half (
  input  logic clk_i,
  input  logic rst_ni,
  output logic half_o
);

  logic half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) half_q <= 1'b0;
    else         half_q <= ~half_q;
  end

  assign half_o = half_q;

  a_r2_half_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_q |=> !half_q);
  a_r2_half_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !half_q |=> half_q);

endmodule

// File: rtl/rdiv_count.sv
module rdiv_count #(
  parameter int unsigned UPW = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  input  rdiv_pkg::ratio_e ratio_i,
  output logic            tc_o,
  output logic            mid_o
);
  import rdiv_pkg::*;

  localparam logic [UPW-1:0] LIM_S = UPW'((1 << (UPW - 1)) - 1);
  localparam logic [UPW-1:0] LIM_L = '1;
  localparam logic [UPW-1:0] MID_S = UPW'((1 << (UPW - 2)) - 1);
  localparam logic [UPW-1:0] MID_L = LIM_S;

  logic [UPW-1:0] up_q;
  logic [UPW-1:0] lim, mid;

  always_comb begin
    lim = (ratio_i == RATIO_LONG) ? LIM_L : LIM_S;
    mid = (ratio_i == RATIO_LONG) ? MID_L : MID_S;
  end

  assign tc_o  = adv_i && (up_q == lim);
  assign mid_o = adv_i && (up_q == mid);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    up_q <= '0;
    else if (tc_o)  up_q <= '0;
    else if (adv_i) up_q <= up_q + 1'b1;
  end

  a_r4_short_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_i == RATIO_SHORT) |-> (up_q <= LIM_S));
  a_r3_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> (up_q == '0));

endmodule

// File: rtl/rdiv_ratio.sv
module rdiv_ratio (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             tc_i,
  output rdiv_pkg::ratio_e ratio_o
);
  import rdiv_pkg::*;

  ratio_e ratio_q;
  logic   armed_q;
  logic   load;

  // first edge after reset, then only period boundaries
  assign load = tc_i || !armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= RATIO_SHORT;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (load) ratio_q <= sel_to_ratio(sel_i);
    end
  end

  assign ratio_o = ratio_q;

  a_r6_ratio_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !tc_i) |=> $stable(ratio_q));

endmodule

// File: rtl/rdiv_out.sv
module rdiv_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tc_i,
  input  logic mid_i,
  output logic stb_o,
  output logic sq_o
);

  logic stb_q, sq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q <= 1'b0;
      sq_q  <= 1'b0;
    end else begin
      stb_q <= tc_i;
      if (tc_i)       sq_q <= 1'b1;
      else if (mid_i) sq_q <= 1'b0;
    end
  end

  assign stb_o = stb_q;
  assign sq_o  = sq_q;

  a_r3_stb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |=> !stb_q);
  a_r7_sq_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sq_q) |-> stb_q);

endmodule

// File: rtl/ref_clk_div.sv
module ref_clk_div #(
  parameter int unsigned SHORT_LOG2 = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ratio_sel_i,
  output logic half_o,
  output logic ref_stb_o,
  output logic ref_sq_o
);
  import rdiv_pkg::*;

  // upper chain counts half-rate periods
  localparam int unsigned UPW = SHORT_LOG2;

  logic   half;
  logic   tc, mid;
  ratio_e ratio;

  rdiv_half u_half (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .half_o (half)
  );

  rdiv_count #(.UPW(UPW)) u_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (half),
    .ratio_i (ratio),
    .tc_o    (tc),
    .mid_o   (mid)
  );

  rdiv_ratio u_ratio (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (ratio_sel_i),
    .tc_i    (tc),
    .ratio_o (ratio)
  );

  rdiv_out u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tc_i   (tc),
    .mid_i  (mid),
    .stb_o  (ref_stb_o),
    .sq_o   (ref_sq_o)
  );

  assign half_o = half;

  a_r3_stb_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_stb_o |-> !half_o);
  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (!half_o && !ref_stb_o && !ref_sq_o));

endmodule

// File: tb/sim_ref_clk_div.sv
`timescale 1ns/1ps
module sim_ref_clk_div;

  localparam int unsigned L  = 4;
  localparam int          NS = 1 << L;
  localparam int          NL = 2 * NS;
  localparam int          NV = 6;
  localparam bit VSEL [NV] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam int VPER [NV] = '{NS, NL, NL, NS, NL, NS};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b1;
  logic half, stb, sq;
  int   tests = 0;
  int   fails = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  ref_clk_div #(.SHORT_LOG2(L)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ratio_sel_i (sel),
    .half_o      (half),
    .ref_stb_o   (stb),
    .ref_sq_o    (sq)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // from a negedge with stb high, count cycles to the next strobe
  task automatic gap(output int n, output int sqhi, input int swap_at, input bit swap_val);
    n = 0;
    sqhi = sq ? 1 : 0;
    for (int k = 0; k < 4 * NL; k++) begin
      @(negedge clk);
      n++;
      if (n == swap_at) sel = swap_val;
      if (stb) break;
      if (sq) sqhi++;
    end
  endtask

  task automatic to_first(output int n, output int half_bad);
    n = 0;
    half_bad = 0;
    for (int k = 0; k < 4 * NL; k++) begin
      @(negedge clk);
      n++;
      if (half != (n % 2)) half_bad++;
      if (stb) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R3 actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int n, sqhi, hb;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 half in reset", half, 0);
    chk("R1 stb in reset", stb, 0);
    chk("R1 sq in reset", sq, 0);
    rst_n = 1'b1;
    // R2/R3: first strobe after one short period
    to_first(n, hb);
    chk("R3 first strobe edge", n, NS);
    chk("R2 half tap pattern errors", hb, 0);
    chk("R7 sq high with strobe", sq, 1);
    // table walk: new select applies to the period after next
    for (int i = 0; i < NV; i++) begin
      sel = VSEL[i];
      gap(n, sqhi, 0, 1'b0);
      gap(n, sqhi, 0, 1'b0);
      chk(VSEL[i] ? "R4 short period" : "R5 long period", n, VPER[i]);
      chk("R7 sq half period", sqhi, VPER[i] / 2);
      chk("R3 stb one cycle", n > 1, 1);
    end
    // R6: select pulse inside a long period
    sel = 1'b0;
    gap(n, sqhi, 0, 1'b0);
    gap(n, sqhi, 0, 1'b0);
    sel = 1'b1;
    gap(n, sqhi, 10, 1'b0);
    chk("R6 pulse keeps long period", n, NL);
    gap(n, sqhi, 0, 1'b0);
    chk("R6 pulse not taken", n, NL);
    // R6: switch to short past short terminal count
    gap(n, sqhi, NS + 4, 1'b1);
    chk("R6 long period not shortened", n, NL);
    gap(n, sqhi, 0, 1'b1);
    chk("R6 short taken at boundary", n, NS);
    // R1/R8: reset mid-run, restart in long ratio
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    sel = 1'b0;
    @(negedge clk);
    chk("R1 half cleared", half, 0);
    chk("R1 stb cleared", stb, 0);
    chk("R1 sq cleared", sq, 0);
    rst_n = 1'b1;
    to_first(n, hb);
    chk("R8 first period long", n, NL);
    chk("R2 half tap after reset", hb, 0);
    gap(n, sqhi, 0, 1'b0);
    chk("R7 sq long half", sqhi, NL / 2);
    finish_run();
  end

endmodule